// File: doc/BRIEF.md
# Per-Channel Video DAC Code Scaler

This block is a three-lane fixed-point gain stage placed just ahead of a set of video DACs. On each clock it accepts one 10-bit sample per lane: lane 0 carries luma or green, lane 1 carries red or Cr, and lane 2 carries blue or Cb. Each lane first subtracts its own programmable black offset, clamping at zero. It then multiplies the remainder by its own unsigned gain code and drops the ten fractional bits. The result is an 11-bit DAC code. Because the output is one bit wider than the input, precision is kept after scaling.

Gains are unsigned fixed point with ten fractional bits. Code 1024 is unity and code 2047 is just under two. Lanes whose input ranges differ can therefore be stretched to a common output swing. For example, luma runs from 64 to 940 while colour difference runs from 64 to 960. Gains and offsets are written through a small write-only register port. A sample is captured together with the settings that are current in its cycle, so a write never splits one sample. The datapath has two register stages, and a valid flag travels alongside it.

Top module: `vid_gain_scaler`

## Requirements
- R1: `out_valid` equals the value `in_valid` had two clock edges earlier.
- R2: For each lane, a valid sample with input `x >= offset` gives `out = min(((x - offset) * gain) >> 10, 2047)`. Lanes are independent, and lane c occupies bits `[10c+9:10c]` of `in_data` and `[11c+10:11c]` of `out_data`.
- R3: A valid sample whose input is below its lane offset produces output code 0.
- R4: While reset is held (synchronous, active high), `out_valid` is 0 and every output code is 0. After reset, every gain is 1024 and every offset is 0, so the output equals the input.
- R5: A write with `cfg_addr[2]` = 0 loads `cfg_wdata[10:0]` into the gain of lane `cfg_addr[1:0]`. A write with `cfg_addr[2]` = 1 loads `cfg_wdata[9:0]` into that lane's offset. Lane numbers are 0 = G/Y, 1 = R/Cr, 2 = B/Cb. Writes with `cfg_addr[1:0]` = 3 change nothing.
- R6: A sample presented in the same cycle as a write is scaled with the old setting. The sample in the next cycle uses the new setting.
- R7: When a cycle carries no valid sample, the output codes two edges later keep their previous values.
- R8: With gains 2047 (lane 0) and 2001 (lanes 1 and 2) and offsets of 64, a luma input of 940 and colour inputs of 960 give outputs that differ by at most one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: bit 2 picks offset or gain, bits 1:0 pick the lane |
| cfg_wdata | input | 11 | Write data |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 30 | Three packed 10-bit input samples, lane 0 in the low bits |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 33 | Three packed 11-bit DAC codes, lane 0 in the low bits |

## Verification
The bound checker watches four properties on every cycle. It confirms the two-edge alignment of the valid flag and that the output codes stay frozen across invalid slots. It also checks that a zero input always gives a zero output and that the outputs are quiet during reset. Only the bench scenarios can show the arithmetic itself: full input ramps under several gain and offset settings, clamping below the offset, the exact cycle at which a register write takes effect, ignored addresses, and the matched full-scale swing across the three lanes.

// File: rtl/vgs_pkg.sv
package vgs_pkg;

    localparam int unsigned VGS_LANES  = 3;
    localparam int unsigned VGS_ADDR_W = 3;

    // Lane identities in lane order
    typedef enum logic [1:0] {
        LANE_GY   = 2'd0,
        LANE_RCR  = 2'd1,
        LANE_BCB  = 2'd2,
        LANE_NONE = 2'd3
    } vgs_lane_e;

    typedef struct packed {
        logic      is_offset;
        vgs_lane_e lane;
    } vgs_addr_t;

    function automatic vgs_addr_t vgs_decode(input logic [VGS_ADDR_W-1:0] a);
        vgs_addr_t d;
        d.is_offset = a[2];
        d.lane      = vgs_lane_e'(a[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/vgs_cfg_regs.sv
module vgs_cfg_regs
    import vgs_pkg::*;
#(
    parameter int unsigned NCH      = 3,
    parameter int unsigned IN_W     = 10,
    parameter int unsigned GAIN_W   = 11,
    parameter int unsigned GAIN_RST = 1024
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [VGS_ADDR_W-1:0]   cfg_addr,
    input  logic [GAIN_W-1:0]       cfg_wdata,
    output logic [NCH*GAIN_W-1:0]   gain_flat,
    output logic [NCH*IN_W-1:0]     off_flat
);

    vgs_addr_t dec;
    assign dec = vgs_decode(cfg_addr);

    for (genvar c = 0; c < NCH; c++) begin : g_lane_regs
        logic [GAIN_W-1:0] gain_q;
        logic [IN_W-1:0]   off_q;
        logic              hit;

        assign hit = cfg_we && (32'(dec.lane) == c);

        always_ff @(posedge clk) begin
            if (rst) begin
                gain_q <= GAIN_W'(GAIN_RST);
                off_q  <= '0;
            end else if (hit) begin
                if (dec.is_offset) begin
                    off_q <= cfg_wdata[IN_W-1:0];
                end else begin
                    gain_q <= cfg_wdata;
                end
            end
        end

        assign gain_flat[c*GAIN_W +: GAIN_W] = gain_q;
        assign off_flat[c*IN_W +: IN_W]      = off_q;
    end

endmodule

// File: rtl/vgs_lane.sv
module vgs_lane #(
    parameter int unsigned IN_W   = 10,
    parameter int unsigned GAIN_W = 11,
    parameter int unsigned FRAC_W = 10,
    parameter int unsigned OUT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s0_valid,
    input  logic              s1_valid,
    input  logic [IN_W-1:0]   in_code,
    input  logic [GAIN_W-1:0] gain,
    input  logic [IN_W-1:0]   offset,
    output logic [OUT_W-1:0]  out_code
);

    localparam int unsigned PROD_W = IN_W + GAIN_W;
    localparam int unsigned SHR_W  = PROD_W - FRAC_W;

    // Stage 1: offset removal with clamp, gain snapshot
    logic [IN_W-1:0]   diff_q;
    logic [GAIN_W-1:0] gain_q;
    logic [IN_W-1:0]   diff_d;

    assign diff_d = (in_code >= offset) ? (in_code - offset) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            diff_q <= '0;
            gain_q <= '0;
        end else if (s0_valid) begin
            diff_q <= diff_d;
            gain_q <= gain;
        end
    end

    // Stage 2: multiply, shift, saturate
    logic [PROD_W-1:0] prod;
    logic [SHR_W-1:0]  scaled;
    logic [OUT_W-1:0]  sat_d;

    assign prod   = PROD_W'(diff_q) * PROD_W'(gain_q);
    assign scaled = prod[PROD_W-1:FRAC_W];

    if (SHR_W > OUT_W) begin : g_sat
        assign sat_d = (scaled > SHR_W'({OUT_W{1'b1}})) ? {OUT_W{1'b1}}
                                                         : scaled[OUT_W-1:0];
    end else if (SHR_W == OUT_W) begin : g_fit
        assign sat_d = scaled;
    end else begin : g_ext
        assign sat_d = OUT_W'(scaled);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_code <= '0;
        end else if (s1_valid) begin
            out_code <= sat_d;
        end
    end

endmodule

// File: rtl/vid_gain_scaler.sv
module vid_gain_scaler
    import vgs_pkg::*;
#(
    parameter int unsigned NCH      = VGS_LANES,
    parameter int unsigned IN_W     = 10,
    parameter int unsigned GAIN_W   = 11,
    parameter int unsigned FRAC_W   = 10,
    parameter int unsigned OUT_W    = 11,
    parameter int unsigned GAIN_RST = 1024
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [GAIN_W-1:0]     cfg_wdata,
    input  logic                  in_valid,
    input  logic [NCH*IN_W-1:0]   in_data,
    output logic                  out_valid,
    output logic [NCH*OUT_W-1:0]  out_data
);

    logic [NCH*GAIN_W-1:0] gain_flat;
    logic [NCH*IN_W-1:0]   off_flat;
    logic                  v1_q;
    logic                  v2_q;

    vgs_cfg_regs #(
        .NCH      (NCH),
        .IN_W     (IN_W),
        .GAIN_W   (GAIN_W),
        .GAIN_RST (GAIN_RST)
    ) cfg_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .gain_flat (gain_flat),
        .off_flat  (off_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        vgs_lane #(
            .IN_W   (IN_W),
            .GAIN_W (GAIN_W),
            .FRAC_W (FRAC_W),
            .OUT_W  (OUT_W)
        ) lane_i (
            .clk      (clk),
            .rst      (rst),
            .s0_valid (in_valid),
            .s1_valid (v1_q),
            .in_code  (in_data[c*IN_W +: IN_W]),
            .gain     (gain_flat[c*GAIN_W +: GAIN_W]),
            .offset   (off_flat[c*IN_W +: IN_W]),
            .out_code (out_data[c*OUT_W +: OUT_W])
        );
    end

    assign out_valid = v2_q;

endmodule

// File: rtl/vgs_checker.sv
module vgs_checker #(
    parameter int unsigned NCH   = 3,
    parameter int unsigned IN_W  = 10,
    parameter int unsigned OUT_W = 11
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [NCH*IN_W-1:0]  in_data,
    input logic                 out_valid,
    input logic [NCH*OUT_W-1:0] out_data
);

    logic [1:0] cyc;
    logic       rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R1: valid flag is delayed by exactly two edges
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7: output codes freeze across an empty slot
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && !$past(in_valid, 2)) |-> (out_data == $past(out_data)));

    // R3: a zero input on lane 0 can never produce a nonzero code
    a_r3_zero_in: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && $past(in_valid, 2) && ($past(in_data[IN_W-1:0], 2) == '0))
        |-> (out_data[OUT_W-1:0] == '0));

    // R4: outputs quiet after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            a_r4_reset: assert (!out_valid && (out_data == '0));
        end
    end

endmodule

bind vid_gain_scaler vgs_checker #(
    .NCH   (NCH),
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/vid_gain_scaler_tb_top.sv
module vid_gain_scaler_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [10:0] cfg_wdata;
    logic        in_valid;
    logic [29:0] in_data;
    logic        out_valid;
    logic [32:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench model state
    int mg[3];
    int mo[3];
    bit pv[2];
    int pd[2][3];
    bit pc[2][3];
    int held[3];

    always #2.5 clk = ~clk;

    vid_gain_scaler dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int model(int x, int off, int g);
        int r;
        if (x < off) return 0;
        r = ((x - off) * g) >>> 10;
        return (r > 2047) ? 2047 : r;
    endfunction

    function automatic int lane_out(int c);
        return int'(out_data[c*11 +: 11]);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: check the entry from two cycles ago, then drive the next one
    task automatic step(bit v, int a, int b, int c, bit w, int addr, int data);
        int x[3];
        @(negedge clk);
        if (pv[1]) begin
            check(out_valid == 1'b1, "R1 valid", int'(out_valid), 1);
            for (int k = 0; k < 3; k++) begin
                check(lane_out(k) == pd[1][k], pc[1][k] ? "R3 clamp" : "R2 scale",
                      lane_out(k), pd[1][k]);
                held[k] = pd[1][k];
            end
        end else begin
            check(out_valid == 1'b0, "R1 idle", int'(out_valid), 0);
            for (int k = 0; k < 3; k++) begin
                check(lane_out(k) == held[k], "R7 hold", lane_out(k), held[k]);
            end
        end
        pv[1] = pv[0];
        pd[1] = pd[0];
        pc[1] = pc[0];
        x[0] = a; x[1] = b; x[2] = c;
        in_valid  = v;
        in_data   = {10'(c), 10'(b), 10'(a)};
        cfg_we    = w;
        cfg_addr  = 3'(addr);
        cfg_wdata = 11'(data);
        pv[0] = v;
        for (int k = 0; k < 3; k++) begin
            pd[0][k] = model(x[k], mo[k], mg[k]);
            pc[0][k] = (x[k] < mo[k]);
        end
        // R6: model register update lands after this sample
        if (w && ((addr & 3) != 3)) begin
            if ((addr & 4) != 0) mo[addr & 3] = data & 1023;
            else                 mg[addr & 3] = data & 2047;
        end
    endtask

    task automatic wr(int addr, int data);
        step(1'b0, 0, 0, 0, 1'b1, addr, data);
    endtask

    task automatic ramp(bit gaps);
        for (int v = 0; v < 1024; v++) begin
            step(!(gaps && (v % 5 == 3)), v, 1023 - v, (v * 37) & 1023, 1'b0, 0, 0);
        end
    endtask

    task automatic drain();
        repeat (3) step(1'b0, 0, 0, 0, 1'b0, 0, 0);
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            mg[k] = 1024; mo[k] = 0; held[k] = 0;
            pd[0][k] = 0; pd[1][k] = 0; pc[0][k] = 0; pc[1][k] = 0;
        end
        pv[0] = 0; pv[1] = 0;
        rst = 1'b1; in_valid = 1'b0; in_data = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        // R4: reset state
        check(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
        check(out_data == '0, "R4 reset data", int'(out_data), 0);
        rst = 1'b0;

        // R4: identity after reset
        ramp(1'b0);
        drain();

        // R5, R8: matched full scale setting
        wr(0, 2047); wr(1, 2001); wr(2, 2001);
        wr(4, 64); wr(5, 64); wr(6, 64);
        ramp(1'b0);
        drain();
        step(1'b1, 940, 960, 960, 1'b0, 0, 0);
        step(1'b0, 0, 0, 0, 1'b0, 0, 0);
        step(1'b0, 0, 0, 0, 1'b0, 0, 0);
        check((lane_out(0) - lane_out(1) <= 1) && (lane_out(1) - lane_out(0) <= 1),
              "R8 match", lane_out(0), lane_out(1));
        drain();

        // R2, R3: zero gain, large offsets
        wr(0, 2047); wr(1, 0); wr(2, 1500);
        wr(4, 0); wr(5, 1023); wr(6, 512);
        ramp(1'b0);
        drain();

        // R5: lane 3 addresses ignored
        wr(3, 0); wr(7, 1000);
        ramp(1'b0);
        drain();

        // R6, R7: writes mid-stream alongside valid samples, with gaps
        for (int v = 0; v < 1024; v++) begin
            bit w = (v % 41 == 7);
            int a = (v % 3) | (((v / 3) & 1) << 2);
            int d = ((a & 4) != 0) ? ((v * 7) & 255) : ((v * 13) & 2047);
            step(!(v % 5 == 3), v, 1023 - v, (v * 37) & 1023, w, a, d);
        end
        drain();
        ramp(1'b1);
        drain();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule